// File: doc/BRIEF.md
# Per-Cycle Gate Protection Sequencer

This block is the isolated-side controller of one gate driver channel. It takes the PWM command as it arrives from across the isolation barrier, plus three comparator flags: supply too low, supply too high, and load over-current. It produces the gate enable and two fault-report lines that carry narrow pulses back to the controller.

Supply health is judged once, on the clock edge where a PWM pulse is first seen high. If the supply is outside its window at that moment, the whole pulse is dropped and the gate never turns on. Supply changes during a running pulse have no effect. The over-current flag is masked while the gate is off and for a blanking interval after each turn-on. A trip after the blanking interval turns the gate off until the command goes low and rises again, and it sends exactly one report pulse. Report pulses use fixed encodings: undervoltage goes on report line 1 at the leading edge, overvoltage goes on report line 2 at the trailing edge, and over-current goes on report line 2 at the moment of the trip.

Top module: `gate_cycle_guard`

## Requirements
- R1: While reset is held, and immediately after its release, gate_o, flt1_o and flt2_o are all 0.
- R2: With the supply valid and no over-current, gate_o equals pwm_i delayed by one clock. A low command always turns the gate off on the next clock.
- R3: If uv_i is 1 on the edge where pwm_i is first sampled high, the gate stays 0 for that whole pulse. flt1_o is 1 for PULSE_CYCLES clocks, starting one clock after that edge.
- R4: If ov_i is 1 on the edge where pwm_i is first sampled high, the gate stays 0 for that whole pulse. flt2_o is 1 for PULSE_CYCLES clocks, starting one clock after the edge where pwm_i is first sampled low.
- R5: uv_i or ov_i becoming 1 after a pulse has started does not change gate_o and produces no report during that pulse.
- R6: The first pulse whose leading edge sees both uv_i and ov_i at 0 drives the gate normally, whatever faults skipped earlier pulses.
- R7: oc_i is ignored during the first BLANK_CYCLES clocks in which gate_o is 1 after each turn-on.
- R8: oc_i sampled at 1 once the blanking interval is over turns gate_o to 0 on the next clock. gate_o then stays 0 until a new pulse begins, and that new pulse drives the gate normally. flt2_o is 1 for PULSE_CYCLES clocks, starting on the same clock that gate_o falls.
- R9: At most one over-current report is sent per PWM pulse, even if oc_i toggles after the trip.
- R10: oc_i has no effect while the gate is off.
- R11: If uv_i and ov_i are both 1 at the leading edge, the pulse is skipped and both reports are sent: flt1_o at the leading edge and flt2_o at the trailing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, synchronous release |
| pwm_i | input | 1 | Restored PWM command |
| uv_i | input | 1 | Supply-below-window comparator flag |
| ov_i | input | 1 | Supply-above-window comparator flag |
| oc_i | input | 1 | Over-current comparator flag |
| gate_o | output | 1 | Gate enable |
| flt1_o | output | 1 | Fault report line 1 (undervoltage) |
| flt2_o | output | 1 | Fault report line 2 (overvoltage, over-current) |

## Verification
Every output is registered. The gate and both report lines respond one clock after the edge that samples the stimulus. A supply report starts one clock after the leading or trailing edge of the command, and an over-current report starts on the same clock that the gate drops. The bench drives each input just after a falling clock edge and predicts the outputs that will be visible after the next rising edge. It queues that prediction, and a monitor compares it 2 ns after the rising edge. The blanking boundary is probed one clock on each side.

// File: rtl/gcg_pkg.sv
`timescale 1ns/1ps
package gcg_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DRIVE = 2'd1,
        PH_TRIP  = 2'd2,
        PH_SKIP  = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   ov_seen;
        logic   gate;
    } seq_state_t;

    localparam int unsigned NUM_FLT = 2;
    localparam int unsigned FLT_UV  = 0;
    localparam int unsigned FLT_OV  = 1;

endpackage

// File: rtl/gcg_edge.sv
`timescale 1ns/1ps
module gcg_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);
    logic lvl_d, lvl_q;

    always_comb begin
        lvl_d  = lvl_i;
        rise_o = lvl_i & ~lvl_q;
        fall_o = ~lvl_i & lvl_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) lvl_q <= 1'b0;
        else         lvl_q <= lvl_d;
    end
endmodule

// File: rtl/gcg_blank.sv
`timescale 1ns/1ps
module gcg_blank #(
    parameter int unsigned LEN = 350
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    input  logic run_i,
    output logic done_o
);
    localparam int unsigned CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LOADV = CW'(LEN);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = LOADV;
        else if (run_i && (cnt_q != '0))
            cnt_d = cnt_q - 1'b1;
        done_o = (cnt_q == '0);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/gcg_pulse.sv
`timescale 1ns/1ps
module gcg_pulse #(
    parameter int unsigned LEN = 20
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic trig_i,
    output logic pulse_o
);
    localparam int unsigned CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LOADV = CW'(LEN);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (trig_i)
            cnt_d = LOADV;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    assign pulse_o = (cnt_q != '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/gate_cycle_guard.sv
`timescale 1ns/1ps
module gate_cycle_guard
    import gcg_pkg::*;
#(
    parameter int unsigned BLANK_CYCLES = 350,
    parameter int unsigned PULSE_CYCLES = 20
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pwm_i,
    input  logic uv_i,
    input  logic ov_i,
    input  logic oc_i,
    output logic gate_o,
    output logic flt1_o,
    output logic flt2_o
);
    seq_state_t st_d, st_q;
    logic pwm_rise, pwm_fall, blank_done;
    logic [NUM_FLT-1:0] flt_trig, flt_out;

    gcg_edge u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (pwm_i),
        .rise_o (pwm_rise),
        .fall_o (pwm_fall)
    );

    gcg_blank #(.LEN(BLANK_CYCLES)) u_blank (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (pwm_rise),
        .run_i  (st_q.gate),
        .done_o (blank_done)
    );

    // Leading-edge supply check, trip handling, report triggers
    always_comb begin
        st_d     = st_q;
        flt_trig = '0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (pwm_rise) begin
                    if (uv_i || ov_i) begin
                        st_d.phase       = PH_SKIP;
                        st_d.ov_seen     = ov_i;
                        st_d.gate        = 1'b0;
                        flt_trig[FLT_UV] = uv_i;
                    end else begin
                        st_d.phase = PH_DRIVE;
                        st_d.gate  = 1'b1;
                    end
                end
            end
            PH_DRIVE: begin
                if (pwm_fall) begin
                    st_d.phase = PH_IDLE;
                    st_d.gate  = 1'b0;
                end else if (blank_done && oc_i) begin
                    st_d.phase       = PH_TRIP;
                    st_d.gate        = 1'b0;
                    flt_trig[FLT_OV] = 1'b1;
                end
            end
            PH_TRIP: begin
                if (pwm_fall) st_d.phase = PH_IDLE;
            end
            PH_SKIP: begin
                if (pwm_fall) begin
                    st_d.phase       = PH_IDLE;
                    flt_trig[FLT_OV] = st_q.ov_seen;
                    st_d.ov_seen     = 1'b0;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{phase: PH_IDLE, ov_seen: 1'b0, gate: 1'b0};
        else         st_q <= st_d;
    end

    for (genvar k = 0; k < NUM_FLT; k++) begin : g_flt
        gcg_pulse #(.LEN(PULSE_CYCLES)) u_pulse (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .trig_i  (flt_trig[k]),
            .pulse_o (flt_out[k])
        );
    end

    assign gate_o = st_q.gate;
    assign flt1_o = flt_out[FLT_UV];
    assign flt2_o = flt_out[FLT_OV];
endmodule

// File: rtl/gate_cycle_guard_chk.sv
`timescale 1ns/1ps
module gate_cycle_guard_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic pwm_i,
    input logic uv_i,
    input logic gate_o,
    input logic flt1_o,
    input logic flt2_o
);
    assert_gate_needs_cmd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(gate_o) |-> $past(pwm_i));

    assert_low_cmd_gate_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pwm_i |=> !gate_o);

    assert_uv_report_at_lead_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(flt1_o) |-> ($past(pwm_i) && $past(uv_i) && !gate_o));

    assert_no_midpulse_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gate_o && pwm_i) |=> (gate_o || $rose(flt2_o)));

    assert_trip_reports_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(gate_o) && $past(pwm_i)) |-> $rose(flt2_o));
endmodule

bind gate_cycle_guard gate_cycle_guard_chk u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pwm_i  (pwm_i),
    .uv_i   (uv_i),
    .gate_o (gate_o),
    .flt1_o (flt1_o),
    .flt2_o (flt2_o)
);

// File: tb/gate_cycle_guard_tb_top.sv
`timescale 1ns/1ps
module gate_cycle_guard_tb_top;
    localparam int BLANK = 350;
    localparam int PULSE = 20;

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic pwm_i = 1'b0, uv_i = 1'b0, ov_i = 1'b0, oc_i = 1'b0;
    logic gate_o, flt1_o, flt2_o;

    always #5 clk = ~clk;

    gate_cycle_guard #(.BLANK_CYCLES(BLANK), .PULSE_CYCLES(PULSE)) dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .pwm_i(pwm_i), .uv_i(uv_i),
        .ov_i(ov_i), .oc_i(oc_i), .gate_o(gate_o), .flt1_o(flt1_o), .flt2_o(flt2_o)
    );

    typedef struct {
        logic  g;
        logic  f1;
        logic  f2;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // expectation model, written from the requirements
    int m_mode = 0;   // 0 waiting, 1 conducting, 2 tripped, 3 skipped
    bit m_prev = 0, m_gate = 0, m_ovs = 0;
    int m_age = 0, m_f1 = 0, m_f2 = 0;

    task automatic step(input bit p, input bit u, input bit o, input bit c, input string req);
        bit t1, t2, rise, fall;
        exp_t e;
        @(negedge clk);
        pwm_i = p; uv_i = u; ov_i = o; oc_i = c;
        rise = p && !m_prev;
        fall = !p && m_prev;
        t1 = 0; t2 = 0;
        case (m_mode)
            0: if (rise) begin
                   if (u || o) begin m_mode = 3; m_ovs = o; t1 = u; end
                   else begin m_mode = 1; m_gate = 1; m_age = 0; end
               end
            1: begin
                   if (fall) begin m_mode = 0; m_gate = 0; end
                   else if (c && m_age >= BLANK) begin m_mode = 2; m_gate = 0; t2 = 1; end
                   else m_age++;
               end
            2: if (fall) m_mode = 0;
            default: if (fall) begin m_mode = 0; t2 = m_ovs; m_ovs = 0; end
        endcase
        m_f1 = t1 ? PULSE : (m_f1 > 0 ? m_f1 - 1 : 0);
        m_f2 = t2 ? PULSE : (m_f2 > 0 ? m_f2 - 1 : 0);
        m_prev = p;
        e.g = m_gate; e.f1 = (m_f1 > 0); e.f2 = (m_f2 > 0); e.req = req;
        exp_q.push_back(e);
    endtask

    // monitor: compares 2 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (gate_o !== e.g || flt1_o !== e.f1 || flt2_o !== e.f2) begin
                    errors++;
                    $display("FAIL %s: gate/flt1/flt2 actual %b%b%b expected %b%b%b at %0t",
                             e.req, gate_o, flt1_o, flt2_o, e.g, e.f1, e.f2, $time);
                end
            end
        end
    end

    task automatic pulse(input int hi, input int lo, input bit u, input bit o, input string req);
        for (int i = 0; i < hi; i++) step(1, u, o, 0, req);
        for (int i = 0; i < lo; i++) step(0, 0, 0, 0, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if ({gate_o, flt1_o, flt2_o} !== 3'b000) begin
            errors++;
            $display("FAIL R1: outputs actual %b%b%b expected 000", gate_o, flt1_o, flt2_o);
        end
        @(negedge clk);
        rst_ni = 1'b1;
        checks++;
        if ({gate_o, flt1_o, flt2_o} !== 3'b000) begin
            errors++;
            $display("FAIL R1: after release actual %b%b%b expected 000", gate_o, flt1_o, flt2_o);
        end
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, "R1");

        pulse(10, 10, 0, 0, "R2");
        pulse(3, 5, 0, 0, "R2");
        // R3: undervoltage at leading edge skips pulse, report on line 1
        pulse(30, 30, 1, 0, "R3");
        // R6: recovery on the next clean pulse
        pulse(10, 10, 0, 0, "R6");
        // R4: overvoltage at lead, removed mid pulse, still reported at trail
        step(1, 0, 1, 0, "R4");
        for (int i = 0; i < 9; i++) step(1, 0, 0, 0, "R4");
        for (int i = 0; i < 30; i++) step(0, 0, 0, 0, "R4");
        pulse(8, 8, 0, 0, "R6");
        // R5: supply faults after start are ignored
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0, "R5");
        for (int i = 0; i < 15; i++) step(1, 1, i % 2, 0, "R5");
        for (int i = 0; i < 25; i++) step(0, 0, 0, 0, "R5");
        // R7: over-current held through the whole blanking window, dropped at its end
        for (int i = 0; i <= BLANK; i++) step(1, 0, 0, 1, "R7");
        for (int i = 0; i < 40; i++) step(1, 0, 0, 0, "R7");
        for (int i = 0; i < 10; i++) step(0, 0, 0, 0, "R7");
        // R8/R9: trip on first clock past blanking, then chatter
        for (int i = 0; i <= BLANK; i++) step(1, 0, 0, 0, "R8");
        step(1, 0, 0, 1, "R8");
        for (int i = 0; i < 40; i++) step(1, 0, 0, i % 3 == 0, "R9");
        for (int i = 0; i < 10; i++) step(0, 0, 0, 0, "R9");
        pulse(12, 10, 0, 0, "R8");
        // R10: over-current while gate is off
        for (int i = 0; i < 20; i++) step(0, 0, 0, 1, "R10");
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, "R10");
        // R11: both supply faults at leading edge
        pulse(6, 30, 1, 1, "R11");
        pulse(10, 10, 0, 0, "R6");

        repeat (3) @(posedge clk);
        #3;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule